// File: doc/BRIEF.md
# Two-Level ALU with Operation Decoder

This block is the arithmetic core of a simple single-cycle processor datapath, together with the small decoder that tells it what to do. Main control supplies a 2-bit operation class. For a register-register instruction the class says "look at the function field", and the 6-bit function field then picks the exact operation. The decoder turns the class and the function field into a 4-bit operation code. The ALU applies that code to two operands.

The ALU performs bitwise and, or, xor and nor, two's-complement add and subtract, and a signed set-on-less-than. Beside the result it reports a zero flag and a signed overflow flag. The flags serve branch equality tests and arithmetic exception logic. The 4-bit operation code is driven out as well, so that the decoder can be checked on its own.

The whole block is combinational and holds no state. An output follows its inputs in the same clock cycle.

Top module: `dlalu_top`

## Requirements
- R1: An operation class of 00 (memory address calculation) yields operation code 0110 (add), whatever the function field holds.
- R2: An operation class of 01 (branch comparison) yields operation code 1110 (subtract), whatever the function field holds.
- R3: An operation class of 10 decodes the function field as follows: 100100 gives and (0000), 100101 gives or (0001), 100110 gives xor (0010), 100111 gives nor (0011), 100000 gives add (0110), 100010 gives subtract (1110), and 101010 gives set-less-than (1111).
- R4: Under class 10, any function value not listed in R3 decodes to add (0110). Class 11 always decodes to add (0110).
- R5: Codes 0000, 0001, 0010 and 0011 produce A&B, A|B, A^B and ~(A|B).
- R6: Code 0110 produces A+B and code 1110 produces A-B, both taken modulo 2^WIDTH.
- R7: Code 1111 produces 1 when A is less than B as signed numbers, and 0 otherwise. The comparison is correct across the whole signed range, including the cases where A-B overflows.
- R8: The zero output is 1 exactly when every bit of the result is 0.
- R9: The overflow output is 1 only for add and subtract, and only when the signed result does not fit in WIDTH bits. It is 0 for the logic operations and for set-less-than.
- R10: The block has no internal state. All outputs settle to the values for the current inputs in the same cycle in which those inputs change, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_class | input | 2 | Operation class from main control |
| fn_field | input | 6 | Function field of the instruction |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| alu_result | output | WIDTH | Operation result |
| alu_zero | output | 1 | Result is all zeros |
| alu_ovf | output | 1 | Signed overflow of add or subtract |
| op_code | output | 4 | Decoded operation code |

## Verification
The block holds no state, so a fault shows at the ports in the same cycle as the input that exposes it. A decoder fault shows up twice in that cycle: op_code is wrong, and the result has the shape of the wrong operation. A fault in how the adder inverts its operand or in its carry-in shows mainly on subtract and on set-less-than. An error in the overflow correction of the comparison appears only when the operand signs differ and their magnitudes are large, so the stimulus places operands at the extremes of the signed range.

// File: rtl/dlalu_pkg.sv
package dlalu_pkg;

    localparam int OPC_W = 4;
    localparam int FN_W  = 6;
    localparam int CLS_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 4'b0000,
        OPC_OR  = 4'b0001,
        OPC_XOR = 4'b0010,
        OPC_NOR = 4'b0011,
        OPC_ADD = 4'b0110,
        OPC_SUB = 4'b1110,
        OPC_SLT = 4'b1111
    } opc_e;

    typedef enum logic [CLS_W-1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_FN  = 2'b10,
        CLS_RSV = 2'b11
    } cls_e;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_XOR = 6'b100110;
    localparam logic [FN_W-1:0] FN_NOR = 6'b100111;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

    // Bit positions inside the operation code that the datapath decodes
    localparam int OPB_SUB   = 3;   // invert B and carry in one
    localparam int OPB_ARITH = 2;   // adder path rather than logic path
    localparam int OPB_SLT   = 0;   // within adder path: compare instead of sum

endpackage

// File: rtl/dlalu_decode.sv
module dlalu_decode
    import dlalu_pkg::*;
(
    input  logic [CLS_W-1:0] op_class,
    input  logic [FN_W-1:0]  fn_field,
    output logic [OPC_W-1:0] op_code
);

    opc_e fn_code;

    // Second level: function field
    always_comb begin
        unique case (fn_field)
            FN_ADD:  fn_code = OPC_ADD;
            FN_SUB:  fn_code = OPC_SUB;
            FN_AND:  fn_code = OPC_AND;
            FN_OR:   fn_code = OPC_OR;
            FN_XOR:  fn_code = OPC_XOR;
            FN_NOR:  fn_code = OPC_NOR;
            FN_SLT:  fn_code = OPC_SLT;
            default: fn_code = OPC_ADD;
        endcase
    end

    // First level: operation class
    always_comb begin
        unique case (cls_e'(op_class))
            CLS_MEM: op_code = OPC_ADD;
            CLS_BR:  op_code = OPC_SUB;
            CLS_FN:  op_code = fn_code;
            default: op_code = OPC_ADD;
        endcase
    end

endmodule

// File: rtl/dlalu_logic.sv
module dlalu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic bit_or;
        assign bit_or = a[i] | b[i];
        always_comb begin
            unique case (sel)
                2'b00:   y[i] = a[i] & b[i];
                2'b01:   y[i] = bit_or;
                2'b10:   y[i] = a[i] ^ b[i];
                default: y[i] = ~bit_or;
            endcase
        end
    end

endmodule

// File: rtl/dlalu_arith.sv
module dlalu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             lt
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    assign b_eff = sub ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    assign sum   = full[MSB:0];

    // Same-signed inputs to the adder giving a differently signed sum
    assign ovf = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

    // Signed less-than: sign of difference, flipped when it overflowed
    assign lt = sum[MSB] ^ ovf;

endmodule

// File: rtl/dlalu_top.sv
module dlalu_top
    import dlalu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [5:0]       fn_field,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] alu_result,
    output logic             alu_zero,
    output logic             alu_ovf,
    output logic [3:0]       op_code
);

    logic [OPC_W-1:0] code;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic             arith_ovf;
    logic             arith_lt;

    dlalu_decode u_decode (
        .op_class (op_class),
        .fn_field (fn_field),
        .op_code  (code)
    );

    dlalu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (code[1:0]),
        .y   (logic_y)
    );

    dlalu_arith #(.WIDTH(WIDTH)) u_arith (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (code[OPB_SUB]),
        .sum (arith_y),
        .ovf (arith_ovf),
        .lt  (arith_lt)
    );

    always_comb begin
        if (!code[OPB_ARITH]) begin
            alu_result = logic_y;
        end else if (code[OPB_SLT]) begin
            alu_result = {{(WIDTH-1){1'b0}}, arith_lt};
        end else begin
            alu_result = arith_y;
        end
    end

    assign alu_ovf  = arith_ovf & code[OPB_ARITH] & ~code[OPB_SLT];
    assign alu_zero = ~|alu_result;
    assign op_code  = code;

endmodule

// File: rtl/dlalu_checker.sv
module dlalu_checker #(
    parameter int WIDTH = 32
) (
    input logic [1:0]       op_class,
    input logic [5:0]       fn_field,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [WIDTH-1:0] alu_result,
    input logic             alu_zero,
    input logic             alu_ovf,
    input logic [3:0]       op_code
);

    always_comb begin
        if (op_class == 2'b00)
            assert_mem_add_R1: assert (op_code == 4'b0110);
        if (op_class == 2'b01)
            assert_branch_sub_R2: assert (op_code == 4'b1110);
        assert_legal_code_R3: assert (op_code inside {4'b0000, 4'b0001, 4'b0010,
                                                      4'b0011, 4'b0110, 4'b1110, 4'b1111});
        if (op_class == 2'b11)
            assert_reserved_add_R4: assert (op_code == 4'b0110);
        if (op_code == 4'b1111)
            assert_slt_single_bit_R7: assert (alu_result[WIDTH-1:1] == '0);
        assert_zero_flag_R8: assert (alu_zero == (alu_result == '0));
        if (op_code[2] == 1'b0 || op_code == 4'b1111)
            assert_no_overflow_R9: assert (!alu_ovf);
        if (op_code == 4'b0110 && opnd_a[WIDTH-1] != opnd_b[WIDTH-1])
            assert_mixed_add_R9: assert (!alu_ovf);
    end

endmodule

bind dlalu_top dlalu_checker #(.WIDTH(WIDTH)) u_dlalu_checker (
    .op_class   (op_class),
    .fn_field   (fn_field),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .alu_result (alu_result),
    .alu_zero   (alu_zero),
    .alu_ovf    (alu_ovf),
    .op_code    (op_code)
);

// File: tb/dlalu_top_bench.sv
module dlalu_top_bench;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   op_class = 2'b00;
    logic [5:0]   fn_field = 6'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic [W-1:0] alu_result;
    logic         alu_zero;
    logic         alu_ovf;
    logic [3:0]   op_code;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    dlalu_top #(.WIDTH(W)) u_dlalu_top (
        .op_class   (op_class),
        .fn_field   (fn_field),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .alu_result (alu_result),
        .alu_zero   (alu_zero),
        .alu_ovf    (alu_ovf),
        .op_code    (op_code)
    );

    typedef struct {
        logic [3:0]   code;
        logic [W-1:0] res;
        logic         zero;
        logic         ovf;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    function automatic logic [3:0] model_code(logic [1:0] c, logic [5:0] f);
        if (c == 2'b00) return 4'b0110;
        if (c == 2'b01) return 4'b1110;
        if (c == 2'b11) return 4'b0110;
        case (f)
            6'b100100: return 4'b0000;
            6'b100101: return 4'b0001;
            6'b100110: return 4'b0010;
            6'b100111: return 4'b0011;
            6'b100000: return 4'b0110;
            6'b100010: return 4'b1110;
            6'b101010: return 4'b1111;
            default:   return 4'b0110;
        endcase
    endfunction

    task automatic drive(input logic [1:0] c, input logic [5:0] f,
                         input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        exp_t   e;
        longint sa, sb, wide;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        e.code = model_code(c, f);
        e.ovf  = 1'b0;
        case (e.code)
            4'b0000: e.res = a & b;
            4'b0001: e.res = a | b;
            4'b0010: e.res = a ^ b;
            4'b0011: e.res = ~(a | b);
            4'b1111: e.res = (sa < sb) ? 1 : 0;
            4'b1110: begin
                wide = sa - sb;
                e.res = a - b;
                e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
            default: begin
                wide = sa + sb;
                e.res = a + b;
                e.ovf = (wide > 64'sd2147483647) || (wide < -64'sd2147483648);
            end
        endcase
        e.zero = (e.res == '0);
        e.tag  = tag;
        @(posedge clk);
        op_class <= c;
        fn_field <= f;
        opnd_a   <= a;
        opnd_b   <= b;
        sb_q.push_back(e);
    endtask

    // Monitor: compare at the falling edge of the cycle in which inputs changed (R10)
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (op_code !== e.code || alu_result !== e.res ||
                    alu_zero !== e.zero || alu_ovf !== e.ovf) begin
                    bad++;
                    $display("FAIL %s R10: got code=%b res=%h z=%b v=%b exp code=%b res=%h z=%b v=%b",
                             e.tag, op_code, alu_result, alu_zero, alu_ovf,
                             e.code, e.res, e.zero, e.ovf);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R10: got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (op_code !== 4'b0110 || alu_result !== '0 || alu_zero !== 1'b1 || alu_ovf !== 1'b0) begin
            bad++;
            $display("FAIL reset R1: got code=%b res=%h z=%b exp code=0110 res=0 z=1",
                     op_code, alu_result, alu_zero);
        end
        rst_n = 1'b1;

        // R1: address add, function ignored
        drive(2'b00, 6'b100100, 32'h0000_1000, 32'hFFFF_FFFC, "R1");
        drive(2'b00, 6'b101010, 32'h1234_0000, 32'h0000_5678, "R1");
        // R2: branch compare, function ignored
        drive(2'b01, 6'b100101, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R2");
        drive(2'b01, 6'b000000, 32'h0000_0005, 32'h0000_0009, "R2");
        // R3: each function code
        drive(2'b10, 6'b100000, 32'h0000_0003, 32'h0000_0004, "R3");
        drive(2'b10, 6'b100010, 32'h0000_0010, 32'h0000_0001, "R3");
        drive(2'b10, 6'b100100, 32'hF0F0_F0F0, 32'hFF00_FF00, "R3");
        drive(2'b10, 6'b100101, 32'hF0F0_F0F0, 32'h0F0F_0000, "R3");
        drive(2'b10, 6'b100110, 32'hAAAA_5555, 32'hFFFF_0000, "R3");
        drive(2'b10, 6'b100111, 32'h0000_FFFF, 32'h00FF_0000, "R3");
        drive(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0000, "R3");
        // R4: undefined function and reserved class
        drive(2'b10, 6'b000000, 32'h0000_0007, 32'h0000_0008, "R4");
        drive(2'b10, 6'b101011, 32'h8000_0000, 32'h8000_0000, "R4");
        drive(2'b11, 6'b100010, 32'h0000_0002, 32'h0000_0003, "R4");
        // R5: logic with extreme patterns
        drive(2'b10, 6'b100100, 32'hFFFF_FFFF, 32'h0000_0000, "R5");
        drive(2'b10, 6'b100111, 32'h0000_0000, 32'h0000_0000, "R5");
        drive(2'b10, 6'b100110, 32'h1234_5678, 32'h1234_5678, "R5");
        // R6: wrap-around
        drive(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'h0000_0001, "R6");
        drive(2'b10, 6'b100010, 32'h0000_0000, 32'h0000_0001, "R6");
        // R7: signed compare across range
        drive(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R7");
        drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R7");
        drive(2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0003, "R7");
        drive(2'b10, 6'b101010, 32'h0000_0003, 32'h0000_0005, "R7");
        drive(2'b10, 6'b101010, 32'h8000_0001, 32'h8000_0001, "R7");
        drive(2'b10, 6'b101010, 32'h8000_0000, 32'h0000_0001, "R7");
        // R8: zero flag
        drive(2'b01, 6'b000000, 32'h8000_0000, 32'h8000_0000, "R8");
        drive(2'b10, 6'b100100, 32'h0F0F_0F0F, 32'hF0F0_F0F0, "R8");
        drive(2'b10, 6'b100101, 32'h0000_0000, 32'h0000_0001, "R8");
        // R9: overflow cases and non-cases
        drive(2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h0000_0001, "R9");
        drive(2'b10, 6'b100010, 32'h8000_0000, 32'h0000_0001, "R9");
        drive(2'b00, 6'b000000, 32'h8000_0000, 32'h8000_0000, "R9");
        drive(2'b10, 6'b100010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9");
        drive(2'b10, 6'b100000, 32'h7FFF_FFFF, 32'h8000_0000, "R9");
        drive(2'b10, 6'b100111, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R9");
        drive(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R9");
        // R10: back-to-back changes of every input, each cycle
        for (int i = 0; i < 16; i++) begin
            drive(2'(i % 3), (i % 2 == 0) ? 6'b101010 : 6'b100110,
                  32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 ^ (i * 32'h0101_0101), "R10");
        end

        wait (sb_q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule